// File: doc/BRIEF.md
# Processor Status and Mode Register

This block keeps the eight-bit flag byte of a sixteen-bit CPU that grew out of an older eight-bit design. It also keeps the single mode bit that chooses between the compatible eight-bit behaviour and the full native behaviour. The instruction decoder, the ALU and the stack sequencer do not write the flag byte directly. They send one-cycle strobes with an operand: swap the carry with the mode bit, clear the flag bits picked by a mask, set the flag bits picked by a mask, or replace the whole byte with a value from the data bus.

From the stored state the block decodes three things for the datapath: whether the accumulator is eight or sixteen bits wide, whether the index registers are eight or sixteen bits wide, and whether the stack is confined to page 1. It also sends a one-cycle pulse to the register file whenever the index width drops to eight bits, so that the upper bytes of both index registers can be cleared.

A separate lookup turns a requested interrupt kind into the bank-0 address of its vector, using the table for the current mode.

Flag byte layout, from bit 7 down to bit 0: N, V, M (accumulator width), X (index width), D, I, Z, C.

Top module: `psr_unit`

## Requirements
- R1: A clock edge with rst_n low loads the flag byte with 0x34 (M=1, X=1, I=1, all other bits 0), sets the mode bit emu_q to 1 and drives idx_trunc low.
- R2: A clock edge with xchg_stb high writes the old carry (bit 0) into emu_q and the old emu_q into the carry.
- R3: While emu_q is 1, bits 5 (M) and 4 (X) read as 1. A clear, load or exchange that would leave either of them 0 has no effect on them, but it still updates the other bits.
- R4: With clr_stb alone and emu_q at 0, every bit set in bit_mask is cleared and every other bit is kept.
- R5: With set_stb alone, every bit set in bit_mask is set and every other bit is kept.
- R6: With load_stb alone and emu_q at 0, the flag byte takes the value of load_data.
- R7: When strobes coincide, the priority is exchange, then load, then set, then clear. Every strobe that loses is ignored.
- R8: acc_narrow is 1 when M=1 or emu_q=1. idx_narrow is 1 when X=1 or emu_q=1. stack_page1 equals emu_q.
- R9: idx_trunc is high for exactly the one cycle after an update that moved X from 0 to 1, and low at all other times.
- R10: With emu_q at 0, vec_kind codes 0..5 (COP, BRK, ABORT, NMI, IRQ, RESET) give vec_addr 0xFFE4, 0xFFE6, 0xFFE8, 0xFFEA, 0xFFEE and 0xFFFC. Codes 6 and 7 act as IRQ.
- R11: With emu_q at 1, the same codes give 0xFFF4, 0xFFFE, 0xFFF8, 0xFFFA, 0xFFFE and 0xFFFC. Codes 6 and 7 act as IRQ.
- R12: A clock edge with no strobe high leaves the flag byte and emu_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xchg_stb | input | 1 | Swap carry with the mode bit |
| clr_stb | input | 1 | Clear the flag bits selected by bit_mask |
| set_stb | input | 1 | Set the flag bits selected by bit_mask |
| load_stb | input | 1 | Replace the flag byte with load_data |
| bit_mask | input | 8 | Immediate mask for clear and set |
| load_data | input | 8 | Flag byte from the data bus |
| vec_kind | input | 3 | Interrupt kind for the vector lookup |
| status_q | output | 8 | Current flag byte |
| emu_q | output | 1 | Mode bit: 1 = compatible eight-bit mode |
| acc_narrow | output | 1 | Accumulator is eight bits wide |
| idx_narrow | output | 1 | Index registers are eight bits wide |
| stack_page1 | output | 1 | Stack pointer is confined to page 1 |
| idx_trunc | output | 1 | One-cycle pulse: clear the upper bytes of the index registers |
| vec_addr | output | 16 | Bank-0 vector address for vec_kind |

## Verification
Every strobe is registered, so the flag byte, emu_q, the three width outputs and idx_trunc all change at the first rising edge after the strobe is presented. The bench drives stimulus at a falling edge and compares against its own model at the following falling edge, one edge later. vec_addr is combinational from vec_kind and the current emu_q, so it is due in the same cycle. The bench changes vec_kind after the falling edge and reads vec_addr one time unit later, well before the next rising edge.

// File: rtl/psr_pkg.sv
// Package: shared constants and types for the status/mode register.
// Assumes the flag byte layout N V M X D I Z C from bit 7 to bit 0.
package psr_pkg;

    localparam int STAT_W = 8;

    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_I = 2;
    localparam int BIT_D = 3;
    localparam int BIT_X = 4;
    localparam int BIT_M = 5;
    localparam int BIT_V = 6;
    localparam int BIT_N = 7;

    // Reset value: M, X and I set; everything else clear.
    localparam logic [STAT_W-1:0] STAT_RESET =
        STAT_W'((1 << BIT_M) | (1 << BIT_X) | (1 << BIT_I));

    typedef enum logic [2:0] {
        VK_COP   = 3'd0,
        VK_BRK   = 3'd1,
        VK_ABORT = 3'd2,
        VK_NMI   = 3'd3,
        VK_IRQ   = 3'd4,
        VK_RESET = 3'd5,
        VK_RSV6  = 3'd6,
        VK_RSV7  = 3'd7
    } vec_kind_e;

    typedef struct packed {
        logic              xchg;
        logic              load;
        logic              set;
        logic              clr;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] data;
    } psr_op_t;

endpackage

// File: rtl/psr_update.sv
// Module: psr_update
// Combinational next-state logic for the flag byte and the mode bit.
// Applies one operation, chosen by the fixed priority exchange > load > set > clear.
// When the resulting mode is emulation, M and X are forced to 1.
// Assumes the operation strobes are already qualified by the caller.
module psr_update
    import psr_pkg::*;
(
    input  logic [STAT_W-1:0] cur_status,
    input  logic              cur_emu,
    input  psr_op_t           op,
    output logic [STAT_W-1:0] nxt_status,
    output logic              nxt_emu,
    output logic              x_raised
);

    logic [STAT_W-1:0] cleared;
    logic [STAT_W-1:0] setbits;
    logic [STAT_W-1:0] swapped;
    logic [STAT_W-1:0] chosen;
    logic [STAT_W-1:0] force_mask;

    // Per-bit masked clear and set, one slice per status bit.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        assign cleared[i] = cur_status[i] & ~op.mask[i];
        assign setbits[i] = cur_status[i] |  op.mask[i];
        assign swapped[i] = (i == BIT_C) ? cur_emu : cur_status[i];
    end

    // Pick the operation result by fixed priority.
    always_comb begin
        chosen  = cur_status;
        nxt_emu = cur_emu;
        if (op.xchg) begin
            chosen  = swapped;
            nxt_emu = cur_status[BIT_C];
        end else if (op.load) begin
            chosen = op.data;
        end else if (op.set) begin
            chosen = setbits;
        end else if (op.clr) begin
            chosen = cleared;
        end
    end

    // In emulation mode the size bits are pinned high.
    always_comb begin
        force_mask        = '0;
        force_mask[BIT_M] = nxt_emu;
        force_mask[BIT_X] = nxt_emu;
        nxt_status        = chosen | force_mask;
    end

    // Detect X moving from 16-bit to 8-bit index width.
    assign x_raised = nxt_status[BIT_X] & ~cur_status[BIT_X];

endmodule

// File: rtl/psr_vector.sv
// Module: psr_vector
// Interrupt vector lookup. Maps an interrupt kind and the current mode to the
// bank-0 address of its vector. The low nibble is an offset from a
// mode-dependent base. Reset always uses the emulation table, since reset
// enters emulation mode.
module psr_vector
    import psr_pkg::*;
#(
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] NATIVE_BASE = 16'hFFE0,
    parameter logic [VEC_W-1:0] EMU_BASE    = 16'hFFF0
) (
    input  logic             emu,
    input  vec_kind_e        kind,
    output logic [VEC_W-1:0] addr
);

    localparam int OFS_W = 4;

    logic [VEC_W-1:0] base;
    logic [OFS_W-1:0] ofs;

    // Select base and offset for the requested kind.
    always_comb begin
        base = emu ? EMU_BASE : NATIVE_BASE;
        case (kind)
            VK_COP:   ofs = 4'h4;
            VK_BRK:   ofs = emu ? 4'hE : 4'h6;
            VK_ABORT: ofs = 4'h8;
            VK_NMI:   ofs = 4'hA;
            VK_RESET: begin
                base = EMU_BASE;
                ofs  = 4'hC;
            end
            default:  ofs = 4'hE;
        endcase
    end

    // Final address: base plus the zero-extended offset.
    assign addr = base + {{(VEC_W-OFS_W){1'b0}}, ofs};

endmodule

// File: rtl/psr_unit.sv
// Module: psr_unit (top)
// Holds the flag byte and the mode bit, runs the flag-manipulation
// operations strobed by the sequencer, decodes the register widths and
// produces the interrupt vector address. The state updates on the clock edge
// after a strobe. The vector output is combinational from the current mode.
// Assumes strobes are single-cycle and qualified elsewhere.
module psr_unit
    import psr_pkg::*;
#(
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] NATIVE_BASE = 16'hFFE0,
    parameter logic [VEC_W-1:0] EMU_BASE    = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xchg_stb,
    input  logic              clr_stb,
    input  logic              set_stb,
    input  logic              load_stb,
    input  logic [STAT_W-1:0] bit_mask,
    input  logic [STAT_W-1:0] load_data,
    input  logic [2:0]        vec_kind,
    output logic [STAT_W-1:0] status_q,
    output logic              emu_q,
    output logic              acc_narrow,
    output logic              idx_narrow,
    output logic              stack_page1,
    output logic              idx_trunc,
    output logic [VEC_W-1:0]  vec_addr
);

    psr_op_t           op;
    logic [STAT_W-1:0] nxt_status;
    logic              nxt_emu;
    logic              x_raised;
    vec_kind_e         kind;

    // Bundle the strobes into one operation record.
    always_comb begin
        op.xchg = xchg_stb;
        op.load = load_stb;
        op.set  = set_stb;
        op.clr  = clr_stb;
        op.mask = bit_mask;
        op.data = load_data;
    end

    psr_update u_update (
        .cur_status (status_q),
        .cur_emu    (emu_q),
        .op         (op),
        .nxt_status (nxt_status),
        .nxt_emu    (nxt_emu),
        .x_raised   (x_raised)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= STAT_RESET;
            emu_q     <= 1'b1;
            idx_trunc <= 1'b0;
        end else begin
            status_q  <= nxt_status;
            emu_q     <= nxt_emu;
            idx_trunc <= x_raised;
        end
    end

    // Width and stack decode for the datapath.
    always_comb begin
        acc_narrow  = status_q[BIT_M] | emu_q;
        idx_narrow  = status_q[BIT_X] | emu_q;
        stack_page1 = emu_q;
    end

    assign kind = vec_kind_e'(vec_kind);

    psr_vector #(
        .VEC_W       (VEC_W),
        .NATIVE_BASE (NATIVE_BASE),
        .EMU_BASE    (EMU_BASE)
    ) u_vector (
        .emu  (emu_q),
        .kind (kind),
        .addr (vec_addr)
    );

endmodule

// File: rtl/psr_unit_chk.sv
// Module: psr_unit_chk
// Property checker for psr_unit. It is attached by the bind below and
// observes the ports only.
module psr_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xchg_stb,
    input logic       clr_stb,
    input logic       set_stb,
    input logic       load_stb,
    input logic [7:0] bit_mask,
    input logic [7:0] load_data,
    input logic [7:0] status_q,
    input logic       emu_q,
    input logic       idx_trunc
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status_q == 8'h34) && emu_q && !idx_trunc);

    assert_exchange_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_stb |=> (emu_q == $past(status_q[0])) && (status_q[0] == $past(emu_q)));

    assert_emu_sizes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        emu_q |-> (status_q[5:4] == 2'b11));

    assert_clear_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb && !load_stb && !xchg_stb && !emu_q)
        |=> ((status_q & $past(bit_mask)) == 8'h00));

    assert_set_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !load_stb && !xchg_stb)
        |=> ((status_q & $past(bit_mask)) == $past(bit_mask)));

    assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !xchg_stb && !emu_q) |=> (status_q == $past(load_data)));

    assert_exchange_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_stb && (clr_stb || set_stb || load_stb))
        |=> (status_q[7:6] == $past(status_q[7:6])) && (status_q[3:1] == $past(status_q[3:1])));

    assert_trunc_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_trunc |-> status_q[4] && !$past(status_q[4]));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!xchg_stb && !clr_stb && !set_stb && !load_stb)
        |=> $stable(status_q) && $stable(emu_q));

endmodule

bind psr_unit psr_unit_chk u_chk (.*);

// File: tb/psr_unit_test.sv
// Bench for psr_unit: directed corner cases followed by seeded random
// operations, all compared against a reference model written in the bench.
module psr_unit_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       xchg_stb, clr_stb, set_stb, load_stb;
    logic [7:0] bit_mask, load_data;
    logic [2:0] vec_kind;
    logic [7:0] status_q;
    logic       emu_q, acc_narrow, idx_narrow, stack_page1, idx_trunc;
    logic [15:0] vec_addr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_s;
    logic       exp_e;
    logic       exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_unit uut (
        .clk(clk), .rst_n(rst_n),
        .xchg_stb(xchg_stb), .clr_stb(clr_stb), .set_stb(set_stb), .load_stb(load_stb),
        .bit_mask(bit_mask), .load_data(load_data), .vec_kind(vec_kind),
        .status_q(status_q), .emu_q(emu_q), .acc_narrow(acc_narrow),
        .idx_narrow(idx_narrow), .stack_page1(stack_page1),
        .idx_trunc(idx_trunc), .vec_addr(vec_addr)
    );

    // Compare one value and report a mismatch.
    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected vector address, written from the tables in R10 and R11.
    function automatic logic [15:0] exp_vec(logic e, logic [2:0] k);
        case (k)
            3'd0:    return e ? 16'hFFF4 : 16'hFFE4;
            3'd1:    return e ? 16'hFFFE : 16'hFFE6;
            3'd2:    return e ? 16'hFFF8 : 16'hFFE8;
            3'd3:    return e ? 16'hFFFA : 16'hFFEA;
            3'd5:    return 16'hFFFC;
            default: return e ? 16'hFFFE : 16'hFFEE;
        endcase
    endfunction

    // Check the vector lookup for one kind in the current mode.
    task automatic check_vec(logic [2:0] k);
        vec_kind = k;
        #1;
        check(exp_e ? "R11" : "R10", "vec_addr", vec_addr, exp_vec(exp_e, k));
    endtask

    // Check every output against the model state.
    task automatic check_all(string req);
        check(req, "status_q", {8'h00, status_q}, {8'h00, exp_s});
        check(req, "emu_q", {15'd0, emu_q}, {15'd0, exp_e});
        check("R9", "idx_trunc", {15'd0, idx_trunc}, {15'd0, exp_t});
        check("R8", "acc_narrow", {15'd0, acc_narrow}, {15'd0, exp_s[5] | exp_e});
        check("R8", "idx_narrow", {15'd0, idx_narrow}, {15'd0, exp_s[4] | exp_e});
        check("R8", "stack_page1", {15'd0, stack_page1}, {15'd0, exp_e});
        check_vec(3'($urandom_range(0, 7)));
    endtask

    // Apply one operation and check the result one edge later.
    task automatic do_op(logic x, logic c, logic s, logic l, logic [7:0] m, logic [7:0] d);
        string      req;
        int         n;
        logic [7:0] ns;
        logic       ne;
        n = int'(x) + int'(c) + int'(s) + int'(l);
        if (n > 1)      req = "R7";
        else if (x)     req = "R2";
        else if (exp_e && (c || l)) req = "R3";
        else if (l)     req = "R6";
        else if (s)     req = "R5";
        else if (c)     req = "R4";
        else            req = "R12";
        ns = exp_s;
        ne = exp_e;
        if (x) begin
            ne    = exp_s[0];
            ns[0] = exp_e;
        end else if (l) begin
            ns = d;
        end else if (s) begin
            ns = exp_s | m;
        end else if (c) begin
            ns = exp_s & ~m;
        end
        if (ne) ns[5:4] = 2'b11;
        xchg_stb = x; clr_stb = c; set_stb = s; load_stb = l;
        bit_mask = m; load_data = d;
        @(posedge clk);
        @(negedge clk);
        xchg_stb = 1'b0; clr_stb = 1'b0; set_stb = 1'b0; load_stb = 1'b0;
        exp_t = ns[4] & ~exp_s[4];
        exp_s = ns;
        exp_e = ne;
        check_all(req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5A17);
        rst_n = 1'b0;
        xchg_stb = 1'b0; clr_stb = 1'b0; set_stb = 1'b0; load_stb = 1'b0;
        bit_mask = 8'h00; load_data = 8'h00; vec_kind = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_s = 8'h34; exp_e = 1'b1; exp_t = 1'b0;
        check_all("R1");
        rst_n = 1'b1;

        // R3: clearing M and X in emulation has no effect on them.
        do_op(0, 1, 0, 0, 8'h30, 8'h00);
        do_op(0, 1, 0, 0, 8'hFF, 8'h00);
        // R11: all emulation vectors.
        for (int k = 0; k < 8; k++) check_vec(3'(k));
        // R2: carry 0, then exchange enters native mode.
        do_op(1, 0, 0, 0, 8'h00, 8'h00);
        for (int k = 0; k < 8; k++) check_vec(3'(k));
        // R4: clear M and X gives 16-bit widths.
        do_op(0, 1, 0, 0, 8'h30, 8'h00);
        // R5 and R9: set X, then the pulse drops.
        do_op(0, 0, 1, 0, 8'h10, 8'h00);
        do_op(0, 0, 0, 0, 8'h00, 8'h00);
        // R6: load a value.
        do_op(0, 0, 0, 1, 8'hC3, 8'h00);
        do_op(0, 0, 0, 1, 8'h00, 8'h0F);
        // R7: load beats set and clear; set beats clear.
        do_op(0, 1, 1, 1, 8'hF0, 8'h81);
        do_op(0, 1, 1, 0, 8'h30, 8'h00);
        do_op(0, 1, 0, 0, 8'hFF, 8'h00);
        // R2 and R3: set carry, exchange back into emulation with X rising.
        do_op(0, 0, 1, 0, 8'h01, 8'h00);
        do_op(1, 0, 0, 0, 8'h00, 8'h00);
        // R7: exchange beats all others.
        do_op(1, 1, 1, 1, 8'hFF, 8'h00);
        do_op(0, 0, 0, 1, 8'h00, 8'hC0);

        // Seeded random mix.
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] m;
            m = ($urandom_range(0, 3) == 0) ? 8'h30 : 8'($urandom);
            do_op(($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                  m, 8'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule